// File: doc/BRIEF.md
# Tagged Stream Receive Queues

This block sits between a user-level network port and a processor core. Words arrive from the network as packets. Each packet begins with a header word that holds its payload length. A tag word follows that names the stream, and then come the payload words. The block compares the tag against a small bank of programmable tag registers. It then steers every payload word of the packet into the receive queue that belongs to the matching register. Software therefore never has to sort interleaved streams itself, and the data never passes through memory on the way to the core.

The core reads a queue the way it reads a register operand. It selects a queue and raises a read enable, and in the same cycle it gets the head word together with a ready flag. If the queue is empty, the flag stays low and the consumer retries. A tag that matches no valid register sends its packet to a catch-all queue, so no traffic is dropped. When the queue chosen for the current packet is full, the block withholds its ready toward the network until a read frees a slot.

Top module: `tagq_demux`

## Requirements
- R1: After reset all five queues are empty, the tag registers are all invalid, and `net_ready` is high because the parser is waiting for a header.
- R2: A packet is a header word, then a tag word, then N payload words, where N is the header's bits [4:0] (0 to 31) and its upper bits are ignored. Header and tag words are never queued, and a packet with N = 0 ends right after its tag.
- R3: The tag is matched once, in the cycle the tag word is taken. All payload words of that packet go to the queue chosen then, even if the tag registers are rewritten mid-packet.
- R4: If several valid tag registers equal the tag, the queue with the lowest index (0 to 3) is chosen.
- R5: A tag that equals no valid tag register sends the payload to the catch-all queue, read with select value 4.
- R6: Writing with `cfg_we` high loads `cfg_tag` and `cfg_valid` into the register picked by `cfg_idx` at the clock edge. A register whose valid bit is 0 never matches.
- R7: While payload is being received and the chosen queue is full at the start of a cycle, `net_ready` is low and no word is taken. Header and tag words are always accepted.
- R8: `rd_sel` values 0 to 3 pick the tagged queues, 4 picks the catch-all queue, and 5 to 7 pick nothing. When `rd_en` is high, `rd_ok` shows the selected queue is non-empty. When `rd_ok` is high, `rd_data` carries the head word in that cycle and the word is removed at the clock edge. A read of an empty queue leaves it unchanged.
- R9: A read and a network write to the same non-empty queue in one cycle both take effect.
- R10: Each queue delivers its words in arrival order.
- R11: Each queue holds exactly 8 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| net_valid | input | 1 | Network word present |
| net_data | input | 32 | Network word (header, tag or payload) |
| net_ready | output | 1 | Block takes the word this cycle |
| cfg_we | input | 1 | Tag register write strobe |
| cfg_idx | input | 2 | Tag register index |
| cfg_tag | input | 32 | Tag value to load |
| cfg_valid | input | 1 | Valid bit to load |
| rd_en | input | 1 | Operand read request |
| rd_sel | input | 3 | Queue select (0-3 tagged, 4 catch-all) |
| rd_data | output | 32 | Head word of the selected queue |
| rd_ok | output | 1 | Read honoured; low means retry |

## Verification
The hardest state to reach from the ports is a stalled payload stream whose target queue is full while a read of that same queue arrives. In that cycle the network word must still be refused, and it must be taken one cycle later. The bench fills a tagged queue with a ten-word packet and holds the ninth word on the port for several refused cycles. It then keeps a read running on that queue while the last two words go in, which also exercises simultaneous push and pop. Rewriting a tag register in the middle of a packet, and giving two registers the same value, cover the point where the queue is chosen and the priority between registers.

// File: rtl/tagq_pkg.sv
package tagq_pkg;
  typedef enum logic [1:0] {
    PH_HDR = 2'd0,
    PH_TAG = 2'd1,
    PH_PAY = 2'd2
  } phase_t;
endpackage

// File: rtl/tagq_fifo.sv
module tagq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full  = (cnt == (AW+1)'(DEPTH));
  assign empty = (cnt == '0);
  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      cnt <= cnt + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop};
    end
  end

  // R7 / R11: never written beyond its depth
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  // R8: never read when empty
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
  // R9: simultaneous push and pop leaves the fill level unchanged
  p_push_pop_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(cnt));
endmodule

// File: rtl/tagq_match.sv
module tagq_match #(
  parameter int NQ = 4,
  parameter int W  = 32,
  localparam int SW = $clog2(NQ + 1)
) (
  input  logic [W-1:0]         tag,
  input  logic [NQ-1:0][W-1:0] tags,
  input  logic [NQ-1:0]        valids,
  output logic [SW-1:0]        sel
);
  logic [NQ-1:0] hits;

  for (genvar i = 0; i < NQ; i++) begin : g_cmp
    assign hits[i] = valids[i] && (tags[i] == tag);
  end

  // lowest set hit wins; no hit selects the catch-all index NQ
  function automatic logic [SW-1:0] first_hit(input logic [NQ-1:0] h);
    logic [SW-1:0] r;
    r = SW'(NQ);
    for (int i = NQ - 1; i >= 0; i--) begin
      if (h[i]) r = SW'(i);
    end
    return r;
  endfunction

  assign sel = first_hit(hits);
endmodule

// File: rtl/tagq_parser.sv
module tagq_parser
  import tagq_pkg::*;
#(
  parameter int W  = 32,
  parameter int LW = 5,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          net_valid,
  input  logic [W-1:0]  net_data,
  output logic          net_ready,
  input  logic [SW-1:0] match_sel,
  input  logic          sel_full,
  output logic          push_en,
  output logic [SW-1:0] cur_sel
);
  phase_t        ph;
  logic [LW-1:0] rem;
  logic          take;

  assign net_ready = (ph != PH_PAY) || !sel_full;
  assign take      = net_valid && net_ready;
  assign push_en   = take && (ph == PH_PAY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= PH_HDR;
      rem     <= '0;
      cur_sel <= '0;
    end else if (take) begin
      unique case (ph)
        PH_HDR: begin
          rem <= net_data[LW-1:0];
          ph  <= PH_TAG;
        end
        PH_TAG: begin
          cur_sel <= match_sel;
          ph      <= (rem == '0) ? PH_HDR : PH_PAY;
        end
        default: begin
          rem <= rem - LW'(1);
          if (rem == LW'(1)) ph <= PH_HDR;
        end
      endcase
    end
  end

  // R2: payload phase always has words left to take
  p_len_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_PAY) |-> (rem != '0));
  // R7: a refused word leaves the packet position and target untouched
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (net_valid && !net_ready) |=> (ph == PH_PAY) && $stable(rem) && $stable(cur_sel));
  // R3: target queue does not change while payload is in flight
  p_target_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_PAY && !(take && rem == LW'(1))) |=> $stable(cur_sel));
endmodule

// File: rtl/tagq_demux.sv
module tagq_demux #(
  parameter int NQ    = 4,
  parameter int W     = 32,
  parameter int DEPTH = 8,
  parameter int LW    = 5,
  localparam int NB   = NQ + 1,
  localparam int SW   = $clog2(NB),
  localparam int IW   = $clog2(NQ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          net_valid,
  input  logic [W-1:0]  net_data,
  output logic          net_ready,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [W-1:0]  cfg_tag,
  input  logic          cfg_valid,
  input  logic          rd_en,
  input  logic [SW-1:0] rd_sel,
  output logic [W-1:0]  rd_data,
  output logic          rd_ok
);
  logic [NQ-1:0][W-1:0] tag_r;
  logic [NQ-1:0]        tag_v;
  logic [SW-1:0]        match_sel, cur_sel;
  logic                 push_en, sel_full, sel_empty;
  logic [NB-1:0]        push_vec, pop_vec, full_v, empty_v;
  logic [NB-1:0][W-1:0] rdata_v;
  logic [W-1:0]         sel_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_r <= '0;
      tag_v <= '0;
    end else if (cfg_we) begin
      tag_r[cfg_idx] <= cfg_tag;
      tag_v[cfg_idx] <= cfg_valid;
    end
  end

  tagq_match #(.NQ(NQ), .W(W)) u_match (
    .tag(net_data), .tags(tag_r), .valids(tag_v), .sel(match_sel)
  );

  tagq_parser #(.W(W), .LW(LW), .SW(SW)) u_parser (
    .clk(clk), .rst_n(rst_n), .net_valid(net_valid), .net_data(net_data),
    .net_ready(net_ready), .match_sel(match_sel), .sel_full(sel_full),
    .push_en(push_en), .cur_sel(cur_sel)
  );

  for (genvar b = 0; b < NB; b++) begin : g_q
    assign push_vec[b] = push_en && (cur_sel == SW'(b));
    assign pop_vec[b]  = rd_en && (rd_sel == SW'(b)) && !empty_v[b];
    tagq_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push_vec[b]), .wdata(net_data),
      .pop(pop_vec[b]), .rdata(rdata_v[b]), .full(full_v[b]), .empty(empty_v[b])
    );
  end

  always_comb begin
    sel_full  = 1'b0;
    sel_empty = 1'b1;
    sel_rdata = '0;
    for (int b = 0; b < NB; b++) begin
      if (cur_sel == SW'(b)) sel_full = full_v[b];
      if (rd_sel == SW'(b)) begin
        sel_empty = empty_v[b];
        sel_rdata = rdata_v[b];
      end
    end
  end

  assign rd_ok   = rd_en && !sel_empty;
  assign rd_data = sel_rdata;

  // R3: a payload word lands in at most one queue
  p_single_target_r3: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(push_vec));
  // R8: at most one queue is drained per cycle, and only when the read is honoured
  p_pop_when_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(pop_vec) <= 1) && (!rd_ok -> (pop_vec == '0)));
endmodule

// File: tb/tagq_demux_test.sv
`timescale 1ns/1ps
module tagq_demux_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        net_valid = 1'b0;
  logic [31:0] net_data = '0;
  logic        net_ready;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_tag = '0;
  logic        cfg_valid = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        rd_ok;

  always #4 clk = ~clk;

  tagq_demux uut (
    .clk(clk), .rst_n(rst_n), .net_valid(net_valid), .net_data(net_data),
    .net_ready(net_ready), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_tag(cfg_tag),
    .cfg_valid(cfg_valid), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .rd_ok(rd_ok)
  );

  // behavioural reference
  logic [31:0] mq [5][$];
  logic [31:0] mtag [4];
  bit          mv [4];
  int          mph, mrem, msel;
  bit          last_acc;
  int          n_cmp = 0, n_bad = 0, cyc = 0;

  function automatic int pick(input logic [31:0] t);
    for (int i = 0; i < 4; i++) if (mv[i] && mtag[i] == t) return i;   // R4 lowest wins
    return 4;                                                            // R5 catch-all
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    bit er, eok;
    int rs;
    logic [31:0] ed;
    #1;
    er  = (mph != 2) || (mq[msel].size() < 8);
    rs  = int'(rd_sel);
    eok = 1'b0;
    ed  = '0;
    if (rd_en && rs < 5) begin
      if (mq[rs].size() > 0) begin
        eok = 1'b1;
        ed  = mq[rs][0];
      end
    end
    chk("R7", "net_ready", {31'd0, net_ready}, {31'd0, er});
    chk("R8", "rd_ok", {31'd0, rd_ok}, {31'd0, eok});
    if (eok) chk("R10", "rd_data", rd_data, ed);
    @(posedge clk);
    last_acc = net_valid && er;
    if (eok) void'(mq[rs].pop_front());
    if (last_acc) begin
      case (mph)
        0: begin mrem = int'(net_data[4:0]); mph = 1; end
        1: begin msel = pick(net_data); mph = (mrem == 0) ? 0 : 2; end
        default: begin
          mq[msel].push_back(net_data);
          mrem--;
          if (mrem == 0) mph = 0;
        end
      endcase
    end
    if (cfg_we) begin mtag[cfg_idx] = cfg_tag; mv[cfg_idx] = cfg_valid; end
    @(negedge clk);
  endtask

  task automatic put(input logic [31:0] w);
    net_valid = 1'b1;
    net_data  = w;
    do step(); while (!last_acc);
    net_valid = 1'b0;
  endtask

  task automatic packet(input logic [31:0] tag, input int len, input logic [31:0] base);
    put(32'h5A5A_0000 | 32'(len));   // R2 upper header bits are junk
    put(tag);
    for (int i = 0; i < len; i++) put(base + 32'(i));
  endtask

  task automatic drain(input int q, input int n);
    rd_en  = 1'b1;
    rd_sel = 3'(q);
    repeat (n) step();
    rd_en  = 1'b0;
  endtask

  task automatic cfg(input int i, input logic [31:0] t, input bit v);
    cfg_we = 1'b1; cfg_idx = 2'(i); cfg_tag = t; cfg_valid = v;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        summary();
      end
    end
  end

  initial begin
    mph = 0; mrem = 0; msel = 0;
    for (int i = 0; i < 4; i++) begin mtag[i] = '0; mv[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    #1;
    chk("R1", "net_ready after reset", {31'd0, net_ready}, 32'd1);
    for (int s = 0; s < 8; s++) begin
      rd_en = 1'b1; rd_sel = 3'(s);
      #1 chk("R1", "rd_ok after reset", {31'd0, rd_ok}, 32'd0);
    end
    rd_en = 1'b0;
    @(negedge clk);

    // R6: program registers; R4 duplicate in queue 2; queue 3 written invalid
    cfg(0, 32'hA, 1); cfg(1, 32'hB, 1); cfg(2, 32'hA, 1); cfg(3, 32'hD, 0);
    packet(32'hA, 3, 32'h100);     // R4 -> queue 0
    packet(32'hB, 2, 32'h200);     // queue 1
    packet(32'hC, 2, 32'h300);     // R5 -> catch-all
    packet(32'hD, 1, 32'h400);     // R6 invalid entry -> catch-all
    packet(32'hE, 0, 32'h0);       // R2 empty packet
    drain(0, 4);                   // R8 last read finds it empty; R10 order
    drain(2, 1);
    drain(1, 2);
    drain(4, 4);
    drain(6, 1);                   // R8 out-of-range select

    // R7 / R11: fill queue 1 to 8 words, then stall
    put(32'h0000_000A); put(32'hB);
    for (int i = 0; i < 8; i++) put(32'h500 + 32'(i));
    net_valid = 1'b1; net_data = 32'h508;
    repeat (3) step();             // refused
    // R9: reading the same queue while the stream continues
    rd_en = 1'b1; rd_sel = 3'd1;
    put(32'h508); put(32'h509);
    rd_en = 1'b0;
    drain(1, 9);

    // R3: rewrite register 0 mid-packet; payload stays in queue 0
    put(32'h4); put(32'hA); put(32'h600); put(32'h601);
    cfg(0, 32'h77, 1);
    put(32'h602); put(32'h603);
    packet(32'hA, 2, 32'h700);     // R4 now goes to queue 2
    drain(0, 5);
    drain(2, 3);

    // R9 / R10: continuous reads of catch-all while it is filled
    rd_en = 1'b1; rd_sel = 3'd4;
    packet(32'hF, 6, 32'h800);
    repeat (3) step();
    rd_en = 1'b0;
    summary();
  end
endmodule